// File: doc/BRIEF.md
# Two-Port Shared-Word Contention Arbiter

This block sits beside a two-port shared memory and decides, every clock, which port may touch a word when both ports point at it. Each port presents an enable, a word address and a write request. Contention exists only when both ports are enabled on the same address. When that happens, the port that was already on that word in the previous cycle keeps access. The other port receives an active-low busy flag, and its write is held back.

A mode strap sets the block as a master or a slave. A master drives its busy outputs with the arbitration result. A slave gets busy flags from an external master, for width expansion, and uses them only to block writes. In slave mode its own busy outputs stay inactive.

All outputs are registered. Inputs sampled at a rising edge show up on the outputs just after that edge.

Top module: `dp_contention_arbiter`

## Requirements
- R1: A busy output goes low only when, at the sampled edge, both enables were high and the two addresses were equal.
- R2: A port counts as already present when, in the previous sampled cycle, it was enabled with the same address it has now. When contention begins, a present port wins against a newly arriving port. The newcomer's busy output goes low one edge after the sampled inputs.
- R3: When neither port was already present, the left port (A) wins. The two busy outputs are never low together.
- R4: While contention continues with both ports unchanged, the winner keeps access cycle after cycle.
- R5: A busy output returns high at the next registered update after the addresses differ or either enable drops.
- R6: With `master_mode` = 1 the busy outputs carry the arbitration result. With `master_mode` = 0 both busy outputs stay high.
- R7: With `master_mode` = 0, each write-ok output is registered as that port's write request ANDed with its busy input.
- R8: With `master_mode` = 1, each write-ok output is registered as that port's write request ANDed with "this port is not losing".
- R9: A synchronous active-high reset sets both busy outputs high and both write-ok outputs low, and clears presence history. After reset, a contention that is already in place is treated as a simultaneous arrival.
- R10: A port that moves its address onto the other port's occupied word loses, even though its enable was already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| master_mode | input | 1 | Strap: 1 = master drives busy, 0 = slave takes busy inputs |
| a_en | input | 1 | Left port enable |
| a_addr | input | ADDR_W | Left port word address |
| a_wr | input | 1 | Left port write request |
| b_en | input | 1 | Right port enable |
| b_addr | input | ADDR_W | Right port word address |
| b_wr | input | 1 | Right port write request |
| a_busy_n_in | input | 1 | Left busy from an external master (slave mode) |
| b_busy_n_in | input | 1 | Right busy from an external master (slave mode) |
| a_busy_n | output | 1 | Left busy, active low |
| b_busy_n | output | 1 | Right busy, active low |
| a_wr_ok | output | 1 | Left write may proceed |
| b_wr_ok | output | 1 | Right write may proceed |

## Verification
The bench targets these corner cases:
- **Arrival by address change rather than by enable.** A design that looks only at enables would hand the word to the port that moved.
- **Both ports moving together onto a new shared word while the right port holds the old one.** A design that carries the old winner across would not apply the left-port tie rule.
- **Reset in the middle of contention.** Stale presence history would make the former winner win again.
- **Slave mode.** A design that kept driving its arbitration result, or ignored the busy inputs, would let a blocked write through or flag a port as busy.

// File: rtl/dpca_pkg.sv
package dpca_pkg;
  localparam int NPORTS = 2;
  localparam int PORT_A = 0;
  localparam int PORT_B = 1;

  // Next winner flags from presence history and the current winner flags.
  function automatic logic [NPORTS-1:0] pick_winner(
    input logic              match,
    input logic [NPORTS-1:0] held,
    input logic [NPORTS-1:0] win_cur
  );
    logic [NPORTS-1:0] nxt;
    nxt = '0;
    if (match) begin
      if (held[PORT_A] && held[PORT_B] && (win_cur != '0))
        nxt = win_cur;
      else if (held[PORT_B] && !held[PORT_A])
        nxt[PORT_B] = 1'b1;
      else
        nxt[PORT_A] = 1'b1;
    end
    return nxt;
  endfunction
endpackage

// File: rtl/dpca_port_track.sv
module dpca_port_track #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic              held
);
  logic              prev_en_q;
  logic [ADDR_W-1:0] prev_addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_en_q   <= 1'b0;
      prev_addr_q <= '0;
    end else begin
      prev_en_q   <= en;
      prev_addr_q <= addr;
    end
  end

  assign held = prev_en_q && en && (prev_addr_q == addr);
endmodule

// File: rtl/dpca_win_track.sv
module dpca_win_track
  import dpca_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              match,
  input  logic [NPORTS-1:0] held,
  output logic [NPORTS-1:0] win_next
);
  logic [NPORTS-1:0] win_q;

  always_comb win_next = pick_winner(match, held, win_q);

  always_ff @(posedge clk) begin
    if (rst) win_q <= '0;
    else     win_q <= win_next;
  end

  // R3: at most one first flag at any time
  p_one_first_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_q));

  // R4: an unchanged contention keeps its winner
  p_keep_winner_r4: assert property (@(posedge clk) disable iff (rst)
    (match && (held == 2'b11) && (win_q != '0)) |=> ($past(win_q) == win_q));
endmodule

// File: rtl/dpca_flag_out.sv
module dpca_flag_out (
  input  logic clk,
  input  logic rst,
  input  logic master_mode,
  input  logic lose_next,
  input  logic wr,
  input  logic busy_n_in,
  output logic busy_n,
  output logic wr_ok
);
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_n <= 1'b1;
      wr_ok  <= 1'b0;
    end else if (master_mode) begin
      busy_n <= !lose_next;
      wr_ok  <= wr && !lose_next;
    end else begin
      busy_n <= 1'b1;
      wr_ok  <= wr && busy_n_in;
    end
  end

  // R6: a slave never asserts its own busy
  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(master_mode) && !$past(rst) |-> busy_n);
endmodule

// File: rtl/dp_contention_arbiter.sv
module dp_contention_arbiter
  import dpca_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              master_mode,
  input  logic              a_en,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_wr,
  input  logic              b_en,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_wr,
  input  logic              a_busy_n_in,
  input  logic              b_busy_n_in,
  output logic              a_busy_n,
  output logic              b_busy_n,
  output logic              a_wr_ok,
  output logic              b_wr_ok
);
  logic              en_v     [NPORTS];
  logic [ADDR_W-1:0] addr_v   [NPORTS];
  logic              wr_v     [NPORTS];
  logic              bin_v    [NPORTS];
  logic              busy_v   [NPORTS];
  logic              ok_v     [NPORTS];
  logic [NPORTS-1:0] held;
  logic [NPORTS-1:0] win_next;
  logic              match;

  assign en_v[PORT_A]   = a_en;
  assign en_v[PORT_B]   = b_en;
  assign addr_v[PORT_A] = a_addr;
  assign addr_v[PORT_B] = b_addr;
  assign wr_v[PORT_A]   = a_wr;
  assign wr_v[PORT_B]   = b_wr;
  assign bin_v[PORT_A]  = a_busy_n_in;
  assign bin_v[PORT_B]  = b_busy_n_in;

  assign match = a_en && b_en && (a_addr == b_addr);

  genvar p;
  generate
    for (p = 0; p < NPORTS; p++) begin : g_port
      dpca_port_track #(.ADDR_W(ADDR_W)) u_track (
        .clk  (clk),
        .rst  (rst),
        .en   (en_v[p]),
        .addr (addr_v[p]),
        .held (held[p])
      );
      dpca_flag_out u_flag (
        .clk         (clk),
        .rst         (rst),
        .master_mode (master_mode),
        .lose_next   (match && !win_next[p]),
        .wr          (wr_v[p]),
        .busy_n_in   (bin_v[p]),
        .busy_n      (busy_v[p]),
        .wr_ok       (ok_v[p])
      );
    end
  endgenerate

  dpca_win_track u_win (
    .clk      (clk),
    .rst      (rst),
    .match    (match),
    .held     (held),
    .win_next (win_next)
  );

  assign a_busy_n = busy_v[PORT_A];
  assign b_busy_n = busy_v[PORT_B];
  assign a_wr_ok  = ok_v[PORT_A];
  assign b_wr_ok  = ok_v[PORT_B];

  // R3: never both ports busy
  p_not_both_busy_r3: assert property (@(posedge clk) disable iff (rst)
    !(!a_busy_n && !b_busy_n));

  // R1: busy only after a sampled address match with both enabled
  p_busy_needs_match_r1: assert property (@(posedge clk) disable iff (rst)
    (!a_busy_n || !b_busy_n) |-> $past(a_en && b_en && (a_addr == b_addr)));

  // R7: a slave port with busy input low gets no write
  p_slave_block_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !master_mode && !a_busy_n_in) |-> !a_wr_ok);

  // R8: a losing master port never gets a write
  p_master_block_r8: assert property (@(posedge clk) disable iff (rst)
    !b_busy_n |-> !b_wr_ok);
endmodule

// File: tb/dp_contention_arbiter_tb.sv
module dp_contention_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 13;
  localparam int WD_CYCLES  = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic master_mode = 1'b1;
  logic a_en = 0, b_en = 0, a_wr = 0, b_wr = 0;
  logic [ADDR_W-1:0] a_addr = '0, b_addr = '0;
  logic a_busy_n_in = 1, b_busy_n_in = 1;
  logic a_busy_n, b_busy_n, a_wr_ok, b_wr_ok;
  int total = 0, bad = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_contention_arbiter #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .a_en(a_en), .a_addr(a_addr), .a_wr(a_wr),
    .b_en(b_en), .b_addr(b_addr), .b_wr(b_wr),
    .a_busy_n_in(a_busy_n_in), .b_busy_n_in(b_busy_n_in),
    .a_busy_n(a_busy_n), .b_busy_n(b_busy_n),
    .a_wr_ok(a_wr_ok), .b_wr_ok(b_wr_ok)
  );

  // Advance one edge; outputs are read at the following falling edge.
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic drive(input logic ae, input int aa, input logic aw,
                       input logic be, input int ba, input logic bw);
    a_en = ae; a_addr = ADDR_W'(aa); a_wr = aw;
    b_en = be; b_addr = ADDR_W'(ba); b_wr = bw;
  endtask

  // expected vector: {a_busy_n, b_busy_n, a_wr_ok, b_wr_ok}
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] got;
    got = {a_busy_n, b_busy_n, a_wr_ok, b_wr_ok};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic t_reset();
    rst = 1; cyc(); cyc();
    chk("R9 reset state", 4'b1100);
    rst = 0;
  endtask

  task automatic t_no_contention();
    drive(1, 5, 1, 1, 6, 1); cyc(); chk("R1 different addresses", 4'b1111);
    drive(1, 7, 1, 0, 7, 0); cyc(); chk("R1 one port disabled", 4'b1110);
  endtask

  task automatic t_left_first();
    drive(1, 7, 1, 1, 7, 1); cyc(); chk("R2 R8 left present wins", 4'b1010);
    cyc();                          chk("R4 winner kept", 4'b1010);
    cyc();                          chk("R4 winner kept again", 4'b1010);
  endtask

  task automatic t_release_and_move();
    drive(1, 7, 1, 1, 8, 1); cyc(); chk("R5 address mismatch releases", 4'b1111);
    drive(1, 7, 1, 1, 7, 1); cyc(); chk("R10 mover loses", 4'b1010);
    drive(0, 7, 0, 1, 7, 1); cyc(); chk("R5 enable drop releases", 4'b1101);
  endtask

  task automatic t_right_first();
    drive(1, 7, 1, 1, 7, 1); cyc(); chk("R2 right present wins", 4'b0101);
    drive(1, 9, 1, 1, 9, 1); cyc(); chk("R3 both move together", 4'b1010);
  endtask

  task automatic t_simultaneous();
    drive(0, 0, 0, 0, 0, 0); cyc(); chk("R5 idle", 4'b1100);
    drive(1, 3, 1, 1, 3, 1); cyc(); chk("R3 simultaneous left wins", 4'b1010);
  endtask

  task automatic t_reset_mid();
    drive(0, 0, 0, 1, 4, 1); cyc(); chk("R1 right alone", 4'b1101);
    drive(1, 4, 1, 1, 4, 1); cyc(); chk("R2 right keeps word", 4'b0101);
    rst = 1; cyc();                 chk("R9 reset during contention", 4'b1100);
    rst = 0; cyc();                 chk("R9 history cleared, tie rule", 4'b1010);
  endtask

  task automatic t_slave();
    master_mode = 0;
    drive(1, 4, 1, 1, 4, 1);
    a_busy_n_in = 1; b_busy_n_in = 1;
    cyc(); chk("R6 R7 slave, inputs high", 4'b1111);
    a_busy_n_in = 0; cyc(); chk("R7 slave left blocked", 4'b1101);
    a_busy_n_in = 1; b_busy_n_in = 0; a_wr = 0;
    cyc(); chk("R7 slave right blocked", 4'b1100);
    b_busy_n_in = 1; cyc(); chk("R6 R7 slave right free", 4'b1101);
  endtask

  initial begin
    t_reset();
    t_no_contention();
    t_left_first();
    t_release_and_move();
    t_right_first();
    t_simultaneous();
    t_reset_mid();
    t_slave();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule